// File: doc/BRIEF.md
# Persistent Output Deviation Classifier

This block watches the stream of 256-bit words leaving a feedback-driven random bit generator and compares every accepted word, bit for bit, with the matching word of a reference stream recorded while no fault was present. Because each output of such a generator feeds the next round, a corrupted internal state never lines up with the reference again. A deviation caused on the transport path, by contrast, disappears on the following words. The block uses this difference to sort every deviation into one of two classes: a persistent fault in the generator core, or a transient event.

An observed word is accepted on a cycle where `obs_valid` is high, and the reference word presented on that same cycle is the one it is compared against. For each word the block reports a mismatch flag and the number of differing bits. It numbers the words, opens a tentative event at the first deviating word and keeps the number of that word as the onset. The event then ends in one of two ways. A run of `RUN_LEN` consecutive deviating words locks the persistent flag. A matching word that arrives earlier closes the event and counts it as transient, so it adds nothing to the fault verdict.

Top module: `dev_classifier`

## Requirements
- R1: One clock edge after an accepted word, `word_mismatch` is 1 if any bit of the observed word differs from the reference word and 0 if they are identical. It keeps that value until the next accepted word.
- R2: `diff_bits` follows the same timing as R1 and gives the number of bit positions in which the two words differ, from 0 to 256.
- R3: After reset, accepted words are numbered 0, 1, 2, … in order of arrival. The number of a word is the count of words accepted before it since reset.
- R4: The word number has `IDX_W` bits (default 32). It saturates at its maximum, so every later word carries that maximum value.
- R5: The Nth word of an unbroken run of `RUN_LEN` (default 8) deviating words sets `persist_fault` two clock edges after that word is accepted. From then on `onset_index` holds the number of the first word of the run. After only `RUN_LEN`-1 deviating words, `persist_fault` is still 0.
- R6: A matching word that ends an open event before the run reaches `RUN_LEN` raises `transient_count` by exactly one and sets `onset_index` back to 0.
- R7: While an event is open and not yet locked, `onset_index` shows the number of the first deviating word of that event. With no event open, it reads 0.
- R8: Once `persist_fault` is set, it stays set until reset. Later words, whether they match or not, change neither `onset_index` nor `transient_count`.
- R9: `transient_count` is `CNT_W` bits wide (default 16) and saturates at its maximum instead of wrapping.
- R10: A synchronous active-high `rst` clears `word_mismatch`, `diff_bits`, `onset_index`, `persist_fault`, `transient_count` and the word numbering.
- R11: A cycle with `obs_valid` low consumes no word number and changes no output, whatever the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obs_valid | input | 1 | Accept the observed word this cycle |
| obs_word | input | 256 | Observed generator output word |
| ref_word | input | 256 | Fault-free reference word for the same position |
| word_mismatch | output | 1 | The last accepted word differed from its reference |
| diff_bits | output | 9 | Number of differing bits in the last accepted word |
| onset_index | output | 32 | Number of the first deviating word of the open or locked event |
| persist_fault | output | 1 | Sticky verdict that the generator state is corrupted |
| transient_count | output | 16 | Number of closed transient events, saturating |

## Verification
The hardest states to reach from the ports are the ones at the edges of the counters: word-number saturation at 2^32−1 and transient-count saturation. Neither can be reached in a short run at the default widths. The bench therefore drives a second instance with a 3-bit word number, a 2-bit transient count and a run length of 2 from the same inputs. On that instance, a tentative onset read after nine words exposes the saturated number, and four short events saturate the count. The run-length boundary is tested on the default instance: first with a run one word short of the threshold, which must end as a transient, and then with a run of exactly the threshold length.

// File: rtl/dev_classifier_pkg.sv
package dev_classifier_pkg;

    localparam int DEF_WORD_W  = 256;
    localparam int DEF_RUN_LEN = 8;
    localparam int DEF_IDX_W   = 32;
    localparam int DEF_CNT_W   = 16;

    typedef enum logic [1:0] {
        CLS_CLEAN   = 2'd0,
        CLS_SUSPECT = 2'd1,
        CLS_LOCKED  = 2'd2
    } cls_state_e;

    function automatic int pop_width(input int word_w);
        return $clog2(word_w + 1);
    endfunction

endpackage

// File: rtl/dev_cmp_stage.sv
module dev_cmp_stage #(
    parameter int WORD_W = dev_classifier_pkg::DEF_WORD_W,
    parameter int POP_W  = dev_classifier_pkg::pop_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_obs,
    input  logic [WORD_W-1:0] in_ref,
    output logic              res_valid,
    output logic              res_mis,
    output logic [POP_W-1:0]  res_pop
);
    logic [WORD_W-1:0] delta;
    logic [POP_W-1:0]  pop_c;

    always_comb begin
        delta = in_obs ^ in_ref;
        pop_c = '0;
        for (int i = 0; i < WORD_W; i++) begin
            pop_c = pop_c + POP_W'(delta[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_mis   <= 1'b0;
            res_pop   <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_mis <= |delta;
                res_pop <= pop_c;
            end
        end
    end

    // R1 / R2: flag and bit count stay consistent
    a_r1_mis_pop: assert property (@(posedge clk) disable iff (rst)
        res_mis == (res_pop != '0));
    a_r2_pop_bound: assert property (@(posedge clk) disable iff (rst)
        res_pop <= POP_W'(WORD_W));
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_mis) && $stable(res_pop)));
endmodule

// File: rtl/dev_idx_stage.sv
module dev_idx_stage #(
    parameter int IDX_W = dev_classifier_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] tag_idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] next_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx <= '0;
            tag_idx  <= '0;
        end else if (adv) begin
            tag_idx <= next_idx;
            if (next_idx != IDX_MAX) begin
                next_idx <= next_idx + 1'b1;
            end
        end
    end

    // R4: numbering moves up by one or holds, never wraps
    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (next_idx != $past(next_idx)) |-> (next_idx == $past(next_idx) + 1'b1));
    // R11: no word number consumed without a valid word
    a_r11_idx_idle: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(next_idx));
endmodule

// File: rtl/dev_cls_fsm.sv
module dev_cls_fsm #(
    parameter int RUN_LEN = dev_classifier_pkg::DEF_RUN_LEN,
    parameter int IDX_W   = dev_classifier_pkg::DEF_IDX_W,
    parameter int CNT_W   = dev_classifier_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic             res_mis,
    input  logic [IDX_W-1:0] res_idx,
    output logic             persist,
    output logic [IDX_W-1:0] onset_idx,
    output logic [CNT_W-1:0] trans_cnt
);
    import dev_classifier_pkg::*;

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cls_state_e       state;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] run_nx;

    assign run_nx  = run_len + 1'b1;
    assign persist = (state == CLS_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CLS_CLEAN;
            run_len   <= '0;
            onset_idx <= '0;
            trans_cnt <= '0;
        end else if (res_valid) begin
            unique case (state)
                CLS_CLEAN: begin
                    if (res_mis) begin
                        onset_idx <= res_idx;
                        run_len   <= RUN_W'(1);
                        state     <= (RUN_LEN <= 1) ? CLS_LOCKED : CLS_SUSPECT;
                    end
                end
                CLS_SUSPECT: begin
                    if (res_mis) begin
                        run_len <= run_nx;
                        if (run_nx >= RUN_LIM) begin
                            state <= CLS_LOCKED;
                        end
                    end else begin
                        state     <= CLS_CLEAN;
                        run_len   <= '0;
                        onset_idx <= '0;
                        if (trans_cnt != CNT_MAX) begin
                            trans_cnt <= trans_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R8: verdict is sticky and freezes the onset
    a_r8_persist_sticky: assert property (@(posedge clk) disable iff (rst)
        persist |=> persist);
    a_r8_onset_frozen: assert property (@(posedge clk) disable iff (rst)
        persist |=> $stable(onset_idx));
    // R6 / R9: transient count steps by one, never wraps
    a_r6_trans_step: assert property (@(posedge clk) disable iff (rst)
        (trans_cnt != $past(trans_cnt)) |-> (trans_cnt == $past(trans_cnt) + 1'b1));
    // R5: locking only follows a deviating word
    a_r5_lock_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(persist) |-> $past(res_valid && res_mis));
endmodule

// File: rtl/dev_classifier.sv
module dev_classifier #(
    parameter int WORD_W  = dev_classifier_pkg::DEF_WORD_W,
    parameter int RUN_LEN = dev_classifier_pkg::DEF_RUN_LEN,
    parameter int IDX_W   = dev_classifier_pkg::DEF_IDX_W,
    parameter int CNT_W   = dev_classifier_pkg::DEF_CNT_W,
    parameter int POP_W   = dev_classifier_pkg::pop_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              obs_valid,
    input  logic [WORD_W-1:0] obs_word,
    input  logic [WORD_W-1:0] ref_word,
    output logic              word_mismatch,
    output logic [POP_W-1:0]  diff_bits,
    output logic [IDX_W-1:0]  onset_index,
    output logic              persist_fault,
    output logic [CNT_W-1:0]  transient_count
);
    logic             cmp_valid;
    logic             cmp_mis;
    logic [IDX_W-1:0] cmp_idx;

    dev_cmp_stage #(.WORD_W(WORD_W), .POP_W(POP_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (obs_valid),
        .in_obs    (obs_word),
        .in_ref    (ref_word),
        .res_valid (cmp_valid),
        .res_mis   (cmp_mis),
        .res_pop   (diff_bits)
    );

    dev_idx_stage #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .adv     (obs_valid),
        .tag_idx (cmp_idx)
    );

    dev_cls_fsm #(.RUN_LEN(RUN_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .res_valid (cmp_valid),
        .res_mis   (cmp_mis),
        .res_idx   (cmp_idx),
        .persist   (persist_fault),
        .onset_idx (onset_index),
        .trans_cnt (transient_count)
    );

    assign word_mismatch = cmp_mis;

    // R10: reset leaves a clean verdict
    a_r10_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (!persist_fault && transient_count == '0));
endmodule

// File: tb/sim_dev_classifier.sv
module sim_dev_classifier;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         obs_valid = 1'b0;
    logic [255:0] obs_word = '0;
    logic [255:0] ref_word = '0;

    logic         mis0;
    logic [8:0]   pop0;
    logic [31:0]  onset0;
    logic         pers0;
    logic [15:0]  trans0;

    logic         mis1;
    logic [8:0]   pop1;
    logic [2:0]   onset1;
    logic         pers1;
    logic [1:0]   trans1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dev_classifier u0 (
        .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_word(obs_word), .ref_word(ref_word),
        .word_mismatch(mis0), .diff_bits(pop0), .onset_index(onset0),
        .persist_fault(pers0), .transient_count(trans0)
    );

    dev_classifier #(.RUN_LEN(2), .IDX_W(3), .CNT_W(2)) u1 (
        .clk(clk), .rst(rst), .obs_valid(obs_valid), .obs_word(obs_word), .ref_word(ref_word),
        .word_mismatch(mis1), .diff_bits(pop1), .onset_index(onset1),
        .persist_fault(pers1), .transient_count(trans1)
    );

    typedef struct packed {
        logic [31:0] seed;
        logic [7:0]  lo;
        logic [8:0]  nflip;
        logic [7:0]  exp_onset;
        logic [3:0]  exp_trans;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{32'h1234_5678, 8'd0,   9'd0,   8'd0, 4'd0},
        '{32'h0BAD_F00D, 8'd0,   9'd1,   8'd1, 4'd0},
        '{32'hCAFE_0001, 8'd0,   9'd0,   8'd0, 4'd1},
        '{32'h5555_AAAA, 8'd0,   9'd256, 8'd3, 4'd1},
        '{32'h0F0F_0F0F, 8'd64,  9'd128, 8'd3, 4'd1},
        '{32'h8000_0001, 8'd253, 9'd3,   8'd3, 4'd1},
        '{32'hDEAD_BEEF, 8'd0,   9'd0,   8'd0, 4'd2},
        '{32'h7777_1111, 8'd0,   9'd0,   8'd0, 4'd2}
    };

    function automatic logic [255:0] mk_ref(input logic [31:0] s);
        logic [255:0] r;
        for (int j = 0; j < 8; j++) r[32*j +: 32] = s * (j + 1) + j;
        return r;
    endfunction

    function automatic logic [255:0] mk_mask(input int lo, input int n);
        logic [255:0] m = '0;
        for (int i = 0; i < 256; i++) if (i >= lo && i < lo + n) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // present one word, leave two edges for the result to settle
    task automatic put(input logic [31:0] seed, input int lo, input int n);
        @(negedge clk);
        ref_word  = mk_ref(seed);
        obs_word  = mk_ref(seed) ^ mk_mask(lo, n);
        obs_valid = 1'b1;
        @(negedge clk);
        obs_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 mismatch", 64'(mis0), 0);
        chk("R10 popcount", 64'(pop0), 0);
        chk("R10 onset", 64'(onset0), 0);
        chk("R10 persist", 64'(pers0), 0);
        chk("R10 transients", 64'(trans0), 0);

        // table walk: R1 R2 R3 R6 R7
        for (int k = 0; k < 8; k++) begin
            put(TBL[k].seed, int'(TBL[k].lo), int'(TBL[k].nflip));
            chk("R1 mismatch", 64'(mis0), 64'(TBL[k].nflip != 0));
            chk("R2 popcount", 64'(pop0), 64'(TBL[k].nflip));
            chk("R7 onset", 64'(onset0), 64'(TBL[k].exp_onset));
            chk("R6 transients", 64'(trans0), 64'(TBL[k].exp_trans));
            chk("R5 no verdict", 64'(pers0), 0);
        end

        // R11: idle cycles with differing data change nothing
        @(negedge clk);
        obs_word = ~ref_word;
        repeat (5) @(negedge clk);
        chk("R11 mismatch held", 64'(mis0), 0);
        chk("R11 transients", 64'(trans0), 2);

        // run one short of the threshold: words 8..14, then match at 15
        for (int k = 0; k < 7; k++) put(32'h100 + k, 10, 5);
        chk("R5 short run no verdict", 64'(pers0), 0);
        chk("R11 onset numbering", 64'(onset0), 8);
        put(32'h200, 0, 0);
        chk("R6 short run transient", 64'(trans0), 3);
        chk("R6 onset cleared", 64'(onset0), 0);

        // exact threshold run: words 16..23
        for (int k = 0; k < 7; k++) put(32'h300 + k, 100, 2);
        chk("R5 seventh word", 64'(pers0), 0);
        put(32'h400, 7, 1);
        chk("R5 verdict", 64'(pers0), 1);
        chk("R5 onset", 64'(onset0), 16);

        // R8 sticky after matches and new mismatches
        put(32'h500, 0, 0);
        put(32'h501, 0, 0);
        put(32'h502, 3, 9);
        put(32'h503, 0, 0);
        chk("R8 persist held", 64'(pers0), 1);
        chk("R8 onset frozen", 64'(onset0), 16);
        chk("R8 transients frozen", 64'(trans0), 3);

        // R10 reset clears and R3 numbering restarts
        do_reset();
        chk("R10 persist cleared", 64'(pers0), 0);
        chk("R10 transients cleared", 64'(trans0), 0);
        chk("R10 onset cleared", 64'(onset0), 0);
        chk("R10 mismatch cleared", 64'(mis0), 0);
        put(32'h600, 0, 0);
        put(32'h601, 50, 4);
        chk("R3 restart numbering", 64'(onset0), 1);
        put(32'h602, 0, 0);

        // R4 and R9 on the narrow instance
        do_reset();
        for (int k = 0; k < 9; k++) put(32'h700 + k, 0, 0);
        put(32'h800, 1, 1);
        chk("R4 saturated number", 64'(onset1), 7);
        chk("R3 wide number", 64'(onset0), 9);
        put(32'h801, 0, 0);
        for (int k = 0; k < 3; k++) begin
            put(32'h900 + k, 2, 2);
            put(32'hA00 + k, 0, 0);
        end
        chk("R9 saturated count", 64'(trans1), 3);
        chk("R9 wide count", 64'(trans0), 4);
        chk("R4 later word", 64'(pers1), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule